// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of the two-wire Ethernet PHY management interface. It generates the management clock and drives the bidirectional data line through separate output, output-enable and input pins. It builds and shifts out complete management frames in either the clause-22 or the clause-45 format. Software controls it through a small register bus: a byte address, a write strobe, 64-bit write data, and a combinational read-data return.

A typical access goes like this. Software writes the payload register, then writes the command register with an operation code, a PHY address and a register or device address. The command write starts one frame. A pending flag on the matching data register stays set until the frame has shifted out. A read frame ends with the 16 captured bits in the read-data register and its valid flag set. In clause 45, a separate address frame carries the register number, taken from the payload register; the following data frame names only the device.

Top module: `mdio_master`

## Requirements
- R1: Byte offsets: command 0x00, payload (write data) 0x08, capture (read data) 0x10, config 0x18, enable 0x20. After reset the following hold: enable bit is 0; both data registers read 0; config reads 0x1004 (clause 22, preamble on, divider 4); the management clock is low; the output enable is low.
- R2: The command register holds the register/device address in [4:0], the PHY address in [12:8] and the operation in [17:16]. These fields read back as written.
- R3: A frame goes out MSB first. It is optional 32 ones (when config bit 12 is set), then 2 start bits, 2 opcode bits, the 5-bit PHY address, the 5-bit register/device address, turnaround `10`, and 16 data bits.
- R4: With config bit 24 clear (clause 22), the start bits are `01`. Only operation bit 0 is used: 0 sends opcode `01` (write, payload from the write-data register) and 1 sends opcode `10` (read).
- R5: With config bit 24 set (clause 45), the start bits are `00` and the opcode on the wire equals the operation field. Operations 0 (address) and 1 (write) send the write-data register as payload. Operations 2 (read with post-increment) and 3 (read) are reads.
- R6: While a frame runs, the management clock toggles every (divider+1) system clocks, where the divider is config [7:0]. Outside a frame it stays low.
- R7: The data output changes only after a falling clock edge. It holds steady while the clock is high, and the input is sampled on the rising edge.
- R8: For a read, the output enable is low for the two turnaround bits and the 16 data bits. At the end of the frame the 16 sampled bits land in capture [15:0], valid (bit 16) is set and pending (bit 17) is cleared.
- R9: A non-read frame sets write-data pending (bit 17) from the cycle after the command write until the frame ends. Writing the write-data register sets its valid flag (bit 16), and a completed non-read frame clears it. A read frame sets capture pending and clears capture valid.
- R10: A command write is ignored while a frame is in progress or while the enable bit is 0. Ignored means no frame, no flag change, and no change of the command register.
- R11: Writing 0 to enable bit 0 aborts a running frame at once. The clock returns low, the output enable drops and both pending flags clear. After re-enabling, new frames run normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 64 | Register write data |
| rdata_o | output | 64 | Register read data for addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situations to reach from the ports are the collisions in time. One is a second command arriving while a frame is mid-shift. Another is the enable bit being cleared part-way through a read. The bench reaches both by launching a frame and then, a fixed number of system clocks later, issuing the competing register write. A scoreboard of expected frames makes any extra or truncated frame show up as an unexpected clock edge or a mismatched bit vector. A bench PHY model drives read data only after falling clock edges, so correct capture shows that sampling happens on the rising edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W   = 6;
  localparam int BUS_W    = 64;
  localparam int PHASE_W  = 8;
  localparam int DATA_W   = 16;
  localparam int PRE_LEN  = 32;
  localparam int FRM_LEN  = 32;
  localparam int SHIFT_W  = PRE_LEN + FRM_LEN;
  localparam int CNT_W    = $clog2(SHIFT_W + 1);

  localparam logic [ADDR_W-1:0] OFF_CMD  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_WDAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_RDAT = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_EN   = 6'h20;

  typedef struct packed {
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] regad;
  } cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               mdc_o,
  output logic               rise_o,
  output logic               fall_o
);
  logic [PHASE_W-1:0] cnt_q;
  logic               mdc_q;
  logic               hit;

  assign hit    = run_i && (cnt_q == phase_i);
  assign rise_o = hit && !mdc_q;
  assign fall_o = hit && mdc_q;
  assign mdc_o  = mdc_q && run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic [SHIFT_W-1:0] frame_i,
  input  logic               long_i,
  input  logic               read_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  cap_o
);
  localparam logic [CNT_W-1:0] LEFT_TA   = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEFT_DATA = CNT_W'(DATA_W);

  logic [SHIFT_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               rd_q, busy_q;
  logic [DATA_W-1:0]  cap_q;

  assign busy_o    = busy_q;
  assign mdio_o    = busy_q ? sh_q[SHIFT_W-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(rd_q && left_q <= LEFT_TA);
  assign done_o    = busy_q && fall_i && (left_q == CNT_W'(1));
  assign cap_o     = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
      cap_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      sh_q   <= frame_i;
      left_q <= long_i ? CNT_W'(SHIFT_W) : CNT_W'(FRM_LEN);
      rd_q   <= read_i;
      busy_q <= 1'b1;
      cap_q  <= '0;
    end else if (busy_q) begin
      // sample on rising clock edge, shift after falling edge
      if (rise_i && rd_q && left_q <= LEFT_DATA)
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        sh_q   <= {sh_q[SHIFT_W-2:0], 1'b1};
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  cmd_t               cmd_q;
  logic [DATA_W-1:0]  wdat_q, rdat_q, cap;
  logic               wval_q, wpend_q, rval_q, rpend_q;
  logic [PHASE_W-1:0] phase_q;
  logic               pre_q, c45_q, en_q;
  logic               busy, done, rise, fall;
  logic               cmd_acc, abort, is_read;
  logic [FRM_LEN-1:0] frm;
  logic [SHIFT_W-1:0] frame;
  cmd_t               cmd_new;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata_i[BUS_W-1:25], wdata_i[23:18], wdata_i[15:13]};

  assign cmd_new = '{op: wdata_i[17:16], phy: wdata_i[12:8], regad: wdata_i[4:0]};
  assign cmd_acc = wr_i && addr_i == OFF_CMD && en_q && !busy;
  assign abort   = wr_i && addr_i == OFF_EN && !wdata_i[0];
  assign is_read = c45_q ? cmd_new.op[1] : cmd_new.op[0];

  always_comb begin
    frm[31:30] = c45_q ? 2'b00 : 2'b01;
    frm[29:28] = c45_q ? cmd_new.op : (cmd_new.op[0] ? 2'b10 : 2'b01);
    frm[27:23] = cmd_new.phy;
    frm[22:18] = cmd_new.regad;
    frm[17:16] = 2'b10;
    frm[15:0]  = is_read ? '1 : wdat_q;
    frame      = pre_q ? {{PRE_LEN{1'b1}}, frm} : {frm, {PRE_LEN{1'b0}}};
  end

  mdio_clkgen #(.PHASE_W(PHASE_W)) u_clk (
    .clk_i, .rst_ni, .run_i(busy), .phase_i(phase_q),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_seq u_seq (
    .clk_i, .rst_ni, .start_i(cmd_acc), .abort_i(abort), .frame_i(frame),
    .long_i(pre_q), .read_i(is_read), .rise_i(rise), .fall_i(fall),
    .mdio_i, .busy_o(busy), .mdio_o, .mdio_oe_o, .done_o(done), .cap_o(cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      wval_q  <= 1'b0;
      wpend_q <= 1'b0;
      rval_q  <= 1'b0;
      rpend_q <= 1'b0;
      phase_q <= PHASE_W'(4);
      pre_q   <= 1'b1;
      c45_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (wr_i && addr_i == OFF_EN) en_q <= wdata_i[0];
      if (wr_i && addr_i == OFF_CFG) begin
        phase_q <= wdata_i[PHASE_W-1:0];
        pre_q   <= wdata_i[12];
        c45_q   <= wdata_i[24];
      end
      if (wr_i && addr_i == OFF_WDAT) begin
        wdat_q <= wdata_i[DATA_W-1:0];
        wval_q <= 1'b1;
      end
      if (abort) begin
        wpend_q <= 1'b0;
        rpend_q <= 1'b0;
      end else if (cmd_acc) begin
        cmd_q <= cmd_new;
        if (is_read) begin
          rpend_q <= 1'b1;
          rval_q  <= 1'b0;
        end else begin
          wpend_q <= 1'b1;
        end
      end else if (done) begin
        wpend_q <= 1'b0;
        rpend_q <= 1'b0;
        if (rpend_q) begin
          rdat_q <= cap;
          rval_q <= 1'b1;
        end else begin
          wval_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CMD:  begin
        rdata_o[17:16] = cmd_q.op;
        rdata_o[12:8]  = cmd_q.phy;
        rdata_o[4:0]   = cmd_q.regad;
      end
      OFF_WDAT: rdata_o[17:0] = {wpend_q, wval_q, wdat_q};
      OFF_RDAT: rdata_o[17:0] = {rpend_q, rval_q, rdat_q};
      OFF_CFG:  begin
        rdata_o[24]          = c45_q;
        rdata_o[12]          = pre_q;
        rdata_o[PHASE_W-1:0] = phase_q;
      end
      OFF_EN:   rdata_o[0] = en_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic              en_q,
  input logic              busy,
  input logic              wpend_q,
  input logic              rpend_q,
  input cmd_t              cmd_q
);
  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o); // R6
  AST_DATA_STEADY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> $stable(mdio_o)); // R7
  AST_OE_ONLY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> busy); // R8
  AST_PEND_CLEAR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (!wpend_q && !rpend_q)); // R9
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_i && addr_i == OFF_CMD) |=> $stable(cmd_q)); // R10
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (!busy && !mdc_o && !mdio_oe_o)); // R11
endmodule

bind mdio_master mdio_master_chk u_chk (.*);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  always #10 clk = ~clk; // 50 MHz

  mdio_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe),
    .mdio_i(mdio_in)
  );

  typedef struct {
    logic [63:0] bits;
    int          len;
    bit          rd;
    logic [15:0] resp;
  } item_t;

  item_t       q[$];
  int          n_chk = 0, n_err = 0;
  int          bitc = 0;
  logic [63:0] got_v = '0;
  bit          oe_bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // scoreboard driver side: expected frame
  task automatic push_frame(input bit pre, input bit c45, input logic [1:0] wire_op,
                            input logic [4:0] phy, input logic [4:0] ra,
                            input bit rd, input logic [15:0] dat);
    item_t it;
    logic [31:0] f;
    f = {c45 ? 2'b00 : 2'b01, wire_op, phy, ra, 2'b10, dat};
    it.bits = pre ? {32'hFFFF_FFFF, f} : {f, 32'h0};
    it.len  = pre ? 64 : 32;
    it.rd   = rd;
    it.resp = dat;
    q.push_back(it);
  endtask

  // monitor: compare shifted bits on each rising management clock edge
  always @(posedge mdc) begin
    if (q.size() == 0) begin
      n_chk++; n_err++;
      $display("FAIL R10 unexpected clock edge actual=1 expected=0");
    end else begin
      got_v[63-bitc] = mdio_out;
      if (q[0].rd && bitc >= q[0].len - 18) begin
        if (mdio_oe !== 1'b0) oe_bad = 1; // R8
      end else if (mdio_oe !== 1'b1) oe_bad = 1;
      bitc++;
      if (bitc == q[0].len) begin
        logic [63:0] m;
        m = ~64'h0 << (64 - (q[0].rd ? q[0].len - 18 : q[0].len));
        chk("R3 frame bits", got_v & m, q[0].bits & m);
        chk("R8 output enable pattern", {63'b0, oe_bad}, 64'h0);
        void'(q.pop_front());
        bitc = 0; got_v = '0; oe_bad = 0;
      end
    end
  end

  // PHY model: drive read data after the falling edge
  always @(negedge mdc) begin
    if (q.size() != 0 && q[0].rd && bitc >= q[0].len - 16 && bitc < q[0].len)
      mdio_in = q[0].resp[15 - (bitc - (q[0].len - 16))];
    else
      mdio_in = 1'b1;
  end

  task automatic reg_wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [63:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle(input logic [5:0] a);
    logic [63:0] d;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      reg_rd(a, d);
      if (!d[17]) return;
    end
    n_chk++; n_err++;
    $display("FAIL R9 pending stuck actual=1 expected=0");
  endtask

  task automatic wait_frames();
    for (int i = 0; i < 5000 && q.size() != 0; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    int half;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_rd(6'h20, d); chk("R1 enable reset", d, 64'h0);
    reg_rd(6'h08, d); chk("R1 wdat reset", d, 64'h0);
    reg_rd(6'h10, d); chk("R1 rdat reset", d, 64'h0);
    reg_rd(6'h18, d); chk("R1 cfg reset", d, 64'h1004);
    chk("R1 pins reset", {62'b0, mdc, mdio_oe}, 64'h0);

    // R10 command while disabled
    reg_wr(6'h00, 64'h0000_0101);
    repeat (50) @(negedge clk);
    reg_rd(6'h08, d); chk("R10 disabled cmd no pending", d, 64'h0);
    reg_rd(6'h00, d); chk("R10 disabled cmd not stored", d, 64'h0);

    reg_wr(6'h20, 64'h1);
    reg_wr(6'h18, 64'h1001); // c22, preamble, divider 1

    // R4 clause-22 write with preamble
    reg_wr(6'h08, 64'hA5C3);
    push_frame(1, 0, 2'b01, 5'h11, 5'h03, 0, 16'hA5C3);
    reg_wr(6'h00, 64'h0000_1103);
    reg_rd(6'h08, d); chk("R9 write pending set", d, 64'h3A5C3);
    reg_rd(6'h00, d); chk("R2 command fields", d, 64'h0000_1103);
    wait_idle(6'h08);
    reg_rd(6'h08, d); chk("R9 write done flags", d, 64'h0A5C3);
    wait_frames();

    // R6 clause-22 read, no preamble, divider 2
    reg_wr(6'h18, 64'h0002);
    push_frame(0, 0, 2'b10, 5'h01, 5'h02, 1, 16'hBEEF);
    reg_wr(6'h00, 64'h0001_0102);
    reg_rd(6'h10, d); chk("R9 read pending set", d, 64'h20000);
    @(posedge mdc);
    half = 0;
    do begin @(posedge clk); #1; half++; end while (mdc);
    chk("R6 half period", 64'(half), 64'd3);
    wait_idle(6'h10);
    reg_rd(6'h10, d); chk("R8 read capture", d, 64'h1BEEF);
    wait_frames();

    // R5 clause-45 address frame, payload from write data
    reg_wr(6'h18, 64'h0100_1001);
    reg_wr(6'h08, 64'h1234);
    push_frame(1, 1, 2'b00, 5'h03, 5'h01, 0, 16'h1234);
    reg_wr(6'h00, 64'h0000_0301);
    wait_idle(6'h08); wait_frames();
    // R5 clause-45 write
    reg_wr(6'h08, 64'h00F0);
    push_frame(1, 1, 2'b01, 5'h03, 5'h01, 0, 16'h00F0);
    reg_wr(6'h00, 64'h0001_0301);
    wait_idle(6'h08); wait_frames();
    // R5 clause-45 read
    push_frame(1, 1, 2'b11, 5'h03, 5'h01, 1, 16'h8001);
    reg_wr(6'h00, 64'h0003_0301);
    wait_idle(6'h10); wait_frames();
    reg_rd(6'h10, d); chk("R5 c45 read data", d, 64'h18001);
    // R5 clause-45 read with post-increment, no preamble
    reg_wr(6'h18, 64'h0100_0001);
    push_frame(0, 1, 2'b10, 5'h03, 5'h01, 1, 16'h7FFE);
    reg_wr(6'h00, 64'h0002_0301);
    wait_idle(6'h10); wait_frames();
    reg_rd(6'h10, d); chk("R5 c45 read-inc data", d, 64'h17FFE);

    // R10 command during a frame is ignored
    reg_wr(6'h18, 64'h0001);
    reg_wr(6'h08, 64'h0F0F);
    push_frame(0, 0, 2'b01, 5'h02, 5'h04, 0, 16'h0F0F);
    reg_wr(6'h00, 64'h0000_0204);
    repeat (20) @(negedge clk);
    reg_wr(6'h00, 64'h0001_0700);
    wait_idle(6'h08);
    repeat (200) @(negedge clk);
    reg_rd(6'h10, d); chk("R10 busy cmd no read", d, 64'h17FFE);
    reg_rd(6'h00, d); chk("R10 busy cmd not stored", d, 64'h0000_0204);

    // R11 abort part-way through a read
    reg_wr(6'h18, 64'h1001);
    push_frame(1, 0, 2'b10, 5'h05, 5'h06, 1, 16'h5555);
    reg_wr(6'h00, 64'h0001_0506);
    repeat (40) @(negedge clk);
    q.delete(); bitc = 0; got_v = '0; oe_bad = 0;
    reg_wr(6'h20, 64'h0);
    repeat (2) @(negedge clk);
    chk("R11 pins idle after abort", {62'b0, mdc, mdio_oe}, 64'h0);
    reg_rd(6'h10, d); chk("R11 pending cleared", d[17:16], 2'b00);
    repeat (200) @(negedge clk);
    // R11 recovery
    reg_wr(6'h20, 64'h1);
    push_frame(1, 0, 2'b10, 5'h05, 5'h06, 1, 16'hC3A1);
    reg_wr(6'h00, 64'h0001_0506);
    wait_idle(6'h10); wait_frames();
    reg_rd(6'h10, d); chk("R11 read after re-enable", d, 64'h1C3A1);
    chk("R3 scoreboard drained", 64'(q.size()), 64'd0);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule